// File: doc/BRIEF.md
# Real-Time Seconds Counter with Match Interrupt

This block keeps time from a 32.768 kHz tick. The block runs on the system clock. The tick arrives as a one-cycle enable pulse, `tick_i`. A 15-bit fraction counter counts the ticks. Each time it wraps, it adds one to a seconds counter. A compare register holds a target seconds value. It can also hold a fraction value that joins the comparison. While the running count equals the target, a raw status flag is forced to 1. The interrupt pin is that flag gated by a mask bit.

Software reaches the block through a plain register port. A write takes one cycle. A read returns data combinationally for the address presented. Through this port software can:
- start and stop the count,
- load a new seconds value,
- stage a new target, which is copied into the comparator on the next tick,
- acknowledge the flag by writing 1 to a clear register.

Setting the flag has priority over clearing it. While the equality holds, an acknowledge is lost. Software can release the flag in two ways. It can load a new count, which ends the equality. It can also stop the counter, because a stopped counter never matches. No data stream passes through the block, so it has no valid/ready port. All pins are plain control and status.

Top module: `rtc_match_timer`

## Requirements
- R1: While running (CTRL bit 0 = 1), each cycle with `tick_i` high adds one to the 15-bit fraction counter. The counter wraps from 32767 to 0.
- R2: The tick that wraps the fraction counter to 0 also adds one to the seconds counter.
- R3: While stopped (CTRL bit 0 = 0), both counters hold their value and no match is signalled.
- R4: A match exists when all three hold: the block is running, the seconds equal the active target, and either bit 15 of the target fraction is 0 or the fraction counter equals target bits 14:0. The raw flag reads 1 from the cycle after the match is first seen.
- R5: Writing 1 to bit 0 of CLEAR drops the raw flag on that same edge, but only if no match holds at that edge. During a match the flag stays 1.
- R6: A write to LOAD replaces the seconds and zeroes the fraction counter. It takes priority over a tick in the same cycle.
- R7: Stopping the counter ends the match, so a following clear succeeds.
- R8: `irq_o` equals raw AND the mask bit (MASK bit 0). The MASKED read returns the same value.
- R9: Writes to TGT_SEC and TGT_FRAC only change the staged copy. The comparator takes the staged copy on the next cycle with `tick_i` high, whether or not the counter runs.
- R10: After reset, all counters, targets, control, mask and the raw flag are 0.
- R11: Register addresses are:

  | Addr | Name | Access | Contents |
  |---|---|---|---|
  | 0 | CTRL | read/write | bit 0 = run |
  | 1 | LOAD | write; reads return the seconds | seconds |
  | 2 | TGT_SEC | read/write | staged target seconds |
  | 3 | TGT_FRAC | read/write | bits 14:0 = target fraction, bit 15 = compare-fraction enable |
  | 4 | MASK | read/write | bit 0 = mask |
  | 5 | CLEAR | write; reads return 0 | bit 0 = clear |
  | 6 | RAW | read | raw flag |
  | 7 | MASKED | read | raw AND mask |
  | 8 | SEC | read | seconds |
  | 9 | FRAC | read | fraction counter |

  Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per 32.768 kHz oscillator period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 32 | Read data, combinational from the read address |
| irq_o | output | 1 | Masked match interrupt |

## Verification
Each kind of internal fault appears at the ports within a known number of cycles:
- A wrong fraction or carry value shows on the FRAC or SEC read at once. It also moves the cycle in which the raw flag rises, by at least one tick.
- A wrong priority between set and clear leaves RAW at the wrong level on the cycle right after the clear write.
- A missing staging step lets the flag rise before any tick occurs.

The bench keeps a behavioural copy of the register state. On every clock it compares the interrupt pin and a rotating read address against that copy. It also makes directed checks at these points:
- the wrap of the fraction counter,
- a clear issued during equality and a clear issued after it,
- a load and a tick in the same cycle,
- a stop followed by a clear.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_ADDR_W = 4;

  typedef enum logic [RTC_ADDR_W-1:0] {
    REG_CTRL   = 4'd0,
    REG_LOAD   = 4'd1,
    REG_TSEC   = 4'd2,
    REG_TFRAC  = 4'd3,
    REG_MASK   = 4'd4,
    REG_CLEAR  = 4'd5,
    REG_RAW    = 4'd6,
    REG_MASKED = 4'd7,
    REG_SEC    = 4'd8,
    REG_FRAC   = 4'd9
  } rtc_reg_e;
endpackage

// File: rtl/rtc_count_chain.sv
module rtc_count_chain #(
  parameter int SUB_W = 15,
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_val_i,
  output logic [SUB_W-1:0] sub_o,
  output logic [SEC_W-1:0] sec_o
);
  localparam logic [SUB_W-1:0] SUB_MAX = {SUB_W{1'b1}};

  logic [SUB_W-1:0] sub_q;
  logic [SEC_W-1:0] sec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q <= '0;
      sec_q <= '0;
    end else if (load_i) begin
      sec_q <= load_val_i;
      sub_q <= '0;
    end else if (run_i && tick_i) begin
      if (sub_q == SUB_MAX) begin
        sub_q <= '0;
        sec_q <= sec_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign sub_o = sub_q;
  assign sec_o = sec_q;

  // R2: wrap of the fraction carries into seconds
  a_r2_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !load_i && sub_q == SUB_MAX)
      |=> (sub_q == '0 && sec_q == $past(sec_q) + 1'b1));

  // R6: load replaces seconds and zeroes the fraction
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sub_q == '0 && sec_q == $past(load_val_i)));

  // R3: stopped counters hold
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> ($stable(sub_q) && $stable(sec_q)));
endmodule

// File: rtl/rtc_match_unit.sv
module rtc_match_unit #(
  parameter int SUB_W   = 15,
  parameter int SEC_W   = 32,
  parameter bit SUB_CMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             wr_sec_i,
  input  logic             wr_sub_i,
  input  logic [SEC_W-1:0] wr_sec_val_i,
  input  logic [SUB_W:0]   wr_sub_val_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SUB_W-1:0] sub_i,
  output logic [SEC_W-1:0] pend_sec_o,
  output logic [SUB_W:0]   pend_sub_o,
  output logic             hit_o
);
  logic [SEC_W-1:0] pend_sec_q, act_sec_q;
  logic [SUB_W:0]   pend_sub_q, act_sub_q;
  logic             sub_eq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_sec_q <= '0;
      pend_sub_q <= '0;
      act_sec_q  <= '0;
      act_sub_q  <= '0;
    end else begin
      if (wr_sec_i) pend_sec_q <= wr_sec_val_i;
      if (wr_sub_i) pend_sub_q <= wr_sub_val_i;
      if (tick_i) begin
        act_sec_q <= pend_sec_q;
        act_sub_q <= pend_sub_q;
      end
    end
  end

  generate
    if (SUB_CMP) begin : g_sub_cmp
      assign sub_eq = !act_sub_q[SUB_W] || (act_sub_q[SUB_W-1:0] == sub_i);
    end else begin : g_sec_only
      assign sub_eq = 1'b1;
    end
  endgenerate

  assign hit_o      = run_i && (act_sec_q == sec_i) && sub_eq;
  assign pend_sec_o = pend_sec_q;
  assign pend_sub_o = pend_sub_q;

  // R9: the active target changes only on a tick
  a_r9_stage: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(act_sec_q) && $stable(act_sub_q)));
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic clr_i,
  input  logic mask_wr_i,
  input  logic mask_val_i,
  output logic raw_o,
  output logic mask_o,
  output logic irq_o
);
  logic raw_q, mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (hit_i)      raw_q <= 1'b1;
      else if (clr_i) raw_q <= 1'b0;
      if (mask_wr_i)  mask_q <= mask_val_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = raw_q & mask_q;

  // R5: set beats clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> raw_q);

  // R5: clear without match drops the flag
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_i && clr_i) |=> !raw_q);

  // R8: pin never active while masked
  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q |-> !irq_o);
endmodule

// File: rtl/rtc_match_timer.sv
module rtc_match_timer
  import rtc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SUB_W   = 15,
  parameter bit SUB_CMP = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  wr_en_i,
  input  logic [RTC_ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [RTC_ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  irq_o
);
  localparam int SEC_W = DATA_W;
  localparam int PAD_W = DATA_W - SUB_W - 1;

  logic             run_q;
  logic             load_wr, tsec_wr, tsub_wr, mask_wr, clr_wr;
  logic [SUB_W-1:0] sub;
  logic [SEC_W-1:0] sec, pend_sec;
  logic [SUB_W:0]   pend_sub;
  logic             hit, raw, mask;

  assign load_wr = wr_en_i && (wr_addr_i == REG_LOAD);
  assign tsec_wr = wr_en_i && (wr_addr_i == REG_TSEC);
  assign tsub_wr = wr_en_i && (wr_addr_i == REG_TFRAC);
  assign mask_wr = wr_en_i && (wr_addr_i == REG_MASK);
  assign clr_wr  = wr_en_i && (wr_addr_i == REG_CLEAR) && wr_data_i[0];

  always_ff @(posedge clk) begin
    if (!rst_n)                                    run_q <= 1'b0;
    else if (wr_en_i && (wr_addr_i == REG_CTRL))   run_q <= wr_data_i[0];
  end

  rtc_count_chain #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .tick_i(tick_i),
    .load_i(load_wr), .load_val_i(wr_data_i),
    .sub_o(sub), .sec_o(sec)
  );

  rtc_match_unit #(.SUB_W(SUB_W), .SEC_W(SEC_W), .SUB_CMP(SUB_CMP)) u_match (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_q),
    .wr_sec_i(tsec_wr), .wr_sub_i(tsub_wr),
    .wr_sec_val_i(wr_data_i), .wr_sub_val_i(wr_data_i[SUB_W:0]),
    .sec_i(sec), .sub_i(sub),
    .pend_sec_o(pend_sec), .pend_sub_o(pend_sub), .hit_o(hit)
  );

  rtc_irq_status u_status (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_i(clr_wr),
    .mask_wr_i(mask_wr), .mask_val_i(wr_data_i[0]),
    .raw_o(raw), .mask_o(mask), .irq_o(irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      REG_CTRL:   rd_data_o = {{(DATA_W-1){1'b0}}, run_q};
      REG_LOAD,
      REG_SEC:    rd_data_o = sec;
      REG_TSEC:   rd_data_o = pend_sec;
      REG_TFRAC:  rd_data_o = {{PAD_W{1'b0}}, pend_sub};
      REG_MASK:   rd_data_o = {{(DATA_W-1){1'b0}}, mask};
      REG_RAW:    rd_data_o = {{(DATA_W-1){1'b0}}, raw};
      REG_MASKED: rd_data_o = {{(DATA_W-1){1'b0}}, irq_o};
      REG_FRAC:   rd_data_o = {{(PAD_W+1){1'b0}}, sub};
      default:    rd_data_o = '0;
    endcase
  end

  // R7: a stopped counter can always be acknowledged
  a_r7_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && clr_wr) |=> !raw);
endmodule

// File: tb/test_rtc_match_timer.sv
`timescale 1ns/1ps
module test_rtc_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_match_timer i_rtc_match_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  // behavioural reference state
  logic [31:0] m_sec, m_psec, m_asec;
  int          m_sub;
  logic [15:0] m_psub, m_asub;
  logic        m_run, m_mask, m_raw, m_hit;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_sub = 0; m_psec = 0; m_asec = 0; m_psub = 0; m_asub = 0;
      m_run = 0; m_mask = 0; m_raw = 0;
    end else begin
      m_hit = m_run && (m_sec == m_asec) && (!m_asub[15] || m_sub == int'(m_asub[14:0]));
      if (m_hit) m_raw = 1'b1;
      else if (wr_en_i && wr_addr_i == 4'd5 && wr_data_i[0]) m_raw = 1'b0;
      if (tick_i) begin m_asec = m_psec; m_asub = m_psub; end
      if (wr_en_i && wr_addr_i == 4'd1) begin
        m_sec = wr_data_i; m_sub = 0;
      end else if (m_run && tick_i) begin
        if (m_sub == 32767) begin m_sub = 0; m_sec = m_sec + 1; end
        else m_sub = m_sub + 1;
      end
      if (wr_en_i) begin
        case (wr_addr_i)
          4'd0: m_run  = wr_data_i[0];
          4'd2: m_psec = wr_data_i;
          4'd3: m_psub = wr_data_i[15:0];
          4'd4: m_mask = wr_data_i[0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    case (a)
      4'd0: return {31'd0, m_run};
      4'd1, 4'd8: return m_sec;
      4'd2: return m_psec;
      4'd3: return {16'd0, m_psub};
      4'd4: return {31'd0, m_mask};
      4'd6: return {31'd0, m_raw};
      4'd7: return {31'd0, m_raw & m_mask};
      4'd9: return 32'(m_sub);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    case (a)
      4'd0: return "R3";
      4'd1, 4'd8: return "R2";
      4'd2, 4'd3: return "R9";
      4'd6: return "R4";
      4'd4, 4'd7: return "R8";
      4'd9: return "R1";
      default: return "R11";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq_o !== (m_raw & m_mask)) begin
        errors++;
        $display("FAIL R8 cycle irq: got %0b exp %0b", irq_o, m_raw & m_mask);
      end
      checks++;
      if (rd_data_o !== exp_rd(rd_addr_i)) begin
        errors++;
        $display("FAIL %s cycle read addr %0d: got %0h exp %0h",
                 tag_of(rd_addr_i), rd_addr_i, rd_data_o, exp_rd(rd_addr_i));
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic drive(bit t, bit we, logic [3:0] a, logic [31:0] d, logic [3:0] ra);
    @(posedge clk); #1;
    tick_i = t; wr_en_i = we; wr_addr_i = a; wr_data_i = d; rd_addr_i = ra;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, bit t = 1'b0);
    drive(t, 1'b1, a, d, 4'd6);
  endtask

  task automatic idle(int n, int per);
    for (int i = 0; i < n; i++) drive((i % per) == per - 1, 1'b0, 4'd0, 32'd0, 4'(i % 10));
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
    drive(1'b0, 1'b0, 4'd0, 32'd0, a);
    @(negedge clk);
    chk(tag, rd_data_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset values
    rd_chk("R10 sec", 4'd8, 32'd0);
    rd_chk("R10 frac", 4'd9, 32'd0);
    rd_chk("R10 raw", 4'd6, 32'd0);
    rd_chk("R10 ctrl", 4'd0, 32'd0);
    chk("R10 irq", {31'd0, irq_o}, 32'd0);

    // R9: staged target has no effect before a tick
    wr(4'd2, 32'd5);
    wr(4'd4, 32'd1);
    wr(4'd1, 32'd5);
    wr(4'd0, 32'd1);
    idle(3, 1000);
    rd_chk("R9 no tick yet", 4'd6, 32'd0);
    drive(1'b1, 1'b0, 4'd0, 32'd0, 4'd6);
    idle(2, 1000);
    rd_chk("R4 raw set", 4'd6, 32'd1);
    chk("R8 irq set", {31'd0, irq_o}, 32'd1);

    // R5: clear loses during equality
    wr(4'd5, 32'd1);
    idle(1, 1000);
    rd_chk("R5 set wins", 4'd6, 32'd1);

    // R8: mask gating
    wr(4'd4, 32'd0);
    rd_chk("R8 masked read", 4'd7, 32'd0);
    chk("R8 irq masked", {31'd0, irq_o}, 32'd0);
    wr(4'd4, 32'd1);

    // R6: load with a tick in the same cycle ends equality, fraction zeroed
    wr(4'd1, 32'd7, 1'b1);
    wr(4'd5, 32'd1);
    rd_chk("R6 release raw", 4'd6, 32'd0);
    rd_chk("R6 sec", 4'd8, 32'd7);
    rd_chk("R6 frac", 4'd9, 32'd0);

    // R7: stop releases the flag
    wr(4'd1, 32'd5);
    idle(2, 1000);
    rd_chk("R7 raw again", 4'd6, 32'd1);
    wr(4'd0, 32'd0);
    wr(4'd5, 32'd1);
    rd_chk("R7 cleared when stopped", 4'd6, 32'd0);

    // R3: stopped counters hold under ticks
    idle(50, 1);
    rd_chk("R3 sec held", 4'd8, 32'd5);
    rd_chk("R3 frac held", 4'd9, 32'd0);
    rd_chk("R3 no match", 4'd6, 32'd0);

    // R4: fraction compare enabled
    wr(4'd2, 32'd9);
    wr(4'd3, 32'h0000_800A);
    wr(4'd1, 32'd9);
    drive(1'b1, 1'b0, 4'd0, 32'd0, 4'd3);
    wr(4'd0, 32'd1);
    idle(5, 1);
    rd_chk("R4 before fraction match", 4'd6, 32'd0);
    idle(15, 1);
    rd_chk("R4 after fraction match", 4'd6, 32'd1);
    wr(4'd5, 32'd1);
    rd_chk("R5 clear after equality", 4'd6, 32'd0);

    // R1: tick every third cycle
    rd_chk("R1 frac start", 4'd9, 32'd20);
    idle(30, 3);
    rd_chk("R1 sparse ticks", 4'd9, 32'd30);

    // R1/R2: wrap and carry
    wr(4'd1, 32'd30);
    idle(32767, 1);
    rd_chk("R1 frac max", 4'd9, 32'd32767);
    rd_chk("R2 sec before wrap", 4'd8, 32'd30);
    drive(1'b1, 1'b0, 4'd0, 32'd0, 4'd9);
    rd_chk("R1 frac wrapped", 4'd9, 32'd0);
    rd_chk("R2 sec carried", 4'd8, 32'd31);

    idle(4, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule